// File: doc/BRIEF.md
# Staggered Multichannel Audio Packet Buffer

This block sits between a serial line decoder that delivers time-multiplexed audio samples and a frame builder that wraps them into network packets. Samples arrive one per write cycle in which `in_valid` is high, cycling through channels 0 to NUM_CH-1 in a fixed order. Each channel has its own dual-clock FIFO. The write side runs in the slow sample domain and the read side runs in the fast transmit domain. Gray-coded pointers carry the occupancy across the two domains.

A channel asks to be sent once its FIFO holds PKT samples. A round-robin arbiter picks one requesting channel. The read side then streams exactly PKT samples of that channel over a valid/ready interface, and marks the last one. To keep the packet sends from bunching, channel k discards its first k*STAGGER samples after reset. The channels therefore reach their send points at times spread across one packet period, and they stay offset after that. A sample that reaches a full channel is dropped, and a sticky error flag is set.

The input has no back-pressure, because the decoder delivers a real-time stream that cannot wait. The output honours back-pressure fully: while `out_valid` is high and `out_ready` is low, the beat on offer does not change. A beat transfers on a rising `rd_clk` edge on which both `out_valid` and `out_ready` are high.

Top module: `staggered_audio_buf`

## Requirements
- R1: Each rising `wr_clk` edge with `in_valid` high assigns `in_data` to the next channel in the order 0, 1, ..., NUM_CH-1, 0, and so on, starting at channel 0 after reset. Cycles with `in_valid` low do not advance the order.
- R2: After reset, channel k discards its first k*STAGGER assigned samples. The first sample it stores is the one from sample period k*STAGGER, where period numbering starts at 0.
- R3: A channel becomes eligible for a packet only while it holds at least PKT stored samples. Packet output never starts for a channel holding fewer.
- R4: A granted packet has exactly PKT beats. The beats are that channel's oldest stored samples in arrival order. `out_chan` stays constant across the packet, and `out_last` is high on the final beat only.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_chan` and `out_last` hold their values into the next cycle.
- R6: When several channels are eligible, the grant goes to the first eligible channel after the most recently served one, in cyclic ascending order.
- R7: A sample assigned to a channel that already holds DEPTH samples is dropped, and the stored samples are kept intact. `ovf_err` then goes high and stays high until `wr_rst_n` is asserted.
- R8: During and right after reset, `out_valid` and `ovf_err` are low.
- R9: `out_valid` stays low while no channel holds PKT samples. A remainder smaller than PKT is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample (write) domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low, asynchronous assert |
| in_valid | input | 1 | A sample is present on `in_data` this cycle |
| in_data | input | DW | Audio sample for the current channel slot |
| ovf_err | output | 1 | Sticky overflow flag, write domain |
| rd_clk | input | 1 | Transmit (read) domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low, asynchronous assert |
| out_valid | output | 1 | A packet beat is on offer |
| out_ready | input | 1 | The frame builder accepts the beat |
| out_data | output | DW | Sample of the packet beat |
| out_chan | output | max(1,clog2(NUM_CH)) | Channel the packet belongs to |
| out_last | output | 1 | Final beat of the packet |

## Verification
The assertions take for granted that both resets are asserted together and held for several cycles of both clocks. They also assume that `out_ready` is driven cleanly relative to `rd_clk`. Packet boundaries are only meaningful if the consumer does not reset the read side in the middle of a packet. The bench keeps within these assumptions: it asserts both resets together for several slow-clock cycles and drives `out_ready` on the falling edge of `rd_clk`, using a fixed on/off pattern during the main stream and a solid low during the overflow stall. Every sample carries its channel number and period index, so the bench predicts each beat arithmetically from the stagger offsets alone.

// File: rtl/sab_pkg.sv
package sab_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_SEND = 1'b1
  } rd_state_e;
endpackage

// File: rtl/sab_chan_fifo.sv
module sab_chan_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int PKT   = 242,
  parameter int SKIP  = 0
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_drop,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_req
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int SKW = $clog2(SKIP + 2);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0]  wbin_q, wgray_q, rg_s1_q, rg_s2_q;
  logic [PW-1:0]  rbin_w, wocc;
  logic [SKW-1:0] skip_q;
  logic           full, skipping, do_wr;

  assign rbin_w   = g2b(rg_s2_q);
  assign wocc     = wbin_q - rbin_w;
  assign full     = (wocc == PW'(DEPTH));
  assign skipping = (skip_q != '0);
  assign do_wr    = wr_en && !skipping && !full;
  assign wr_drop  = wr_en && !skipping && full;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_s1_q <= '0;
      rg_s2_q <= '0;
      skip_q  <= SKW'(SKIP);
    end else begin
      rg_s1_q <= rgray_q;
      rg_s2_q <= rg_s1_q;
      if (wr_en && skipping) skip_q <= skip_q - 1'b1;
      if (do_wr) begin
        wbin_q  <= wbin_q + 1'b1;
        wgray_q <= b2g(wbin_q + 1'b1);
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (do_wr) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  // read domain
  logic [PW-1:0] rbin_q, rgray_q, wg_s1_q, wg_s2_q;
  logic [PW-1:0] wbin_r, rocc;

  assign wbin_r  = g2b(wg_s2_q);
  assign rocc    = wbin_r - rbin_q;
  assign rd_req  = (rocc >= PW'(PKT));
  assign rd_data = mem[rbin_q[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1_q <= '0;
      wg_s2_q <= '0;
    end else begin
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
      if (rd_pop) begin
        rbin_q  <= rbin_q + 1'b1;
        rgray_q <= b2g(rbin_q + 1'b1);
      end
    end
  end
endmodule

// File: rtl/sab_wr_seq.sv
module sab_wr_seq #(
  parameter int NUM_CH = 8,
  localparam int CIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NUM_CH-1:0] drop_vec,
  output logic [NUM_CH-1:0] wr_en_vec,
  output logic              ovf_err
);
  logic [CIW-1:0] slot_q;

  always_comb begin
    wr_en_vec = '0;
    if (in_valid) wr_en_vec[slot_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (|drop_vec) ovf_err <= 1'b1;
      if (in_valid) begin
        if (slot_q == CIW'(NUM_CH - 1)) slot_q <= '0;
        else                            slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sab_rr_arb.sv
module sab_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = N; i >= 1; i--) begin
      int j;
      j = (int'(last_q) + i) % N;
      if (req[j]) begin
        gnt     = '0;
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
        any     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_q <= IW'(N - 1);
    else if (take && any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/staggered_audio_buf.sv
module staggered_audio_buf
  import sab_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NUM_CH  = 8,
  parameter int DEPTH   = 256,
  parameter int PKT     = 242,
  parameter int STAGGER = PKT / NUM_CH,
  localparam int CIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic           wr_clk,
  input  logic           wr_rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_data,
  output logic           ovf_err,
  input  logic           rd_clk,
  input  logic           rd_rst_n,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic [CIW-1:0] out_chan,
  output logic           out_last
);
  localparam int BW = (PKT > 1) ? $clog2(PKT) : 1;

  logic [NUM_CH-1:0] wr_en_vec, drop_vec, req_vec, pop_vec, arb_gnt;
  logic [DW-1:0]     rdat [NUM_CH];
  logic [CIW-1:0]    arb_idx, sel_q;
  logic              arb_any, arb_take;
  logic [BW-1:0]     beat_q;
  rd_state_e         state_q;

  sab_wr_seq #(.NUM_CH(NUM_CH)) u_wseq (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid),
    .drop_vec(drop_vec), .wr_en_vec(wr_en_vec), .ovf_err(ovf_err)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    sab_chan_fifo #(
      .DW(DW), .DEPTH(DEPTH), .PKT(PKT), .SKIP(k * STAGGER)
    ) u_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en_vec[k]),
      .wr_data(in_data), .wr_drop(drop_vec[k]),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_pop(pop_vec[k]),
      .rd_data(rdat[k]), .rd_req(req_vec[k])
    );
  end

  assign arb_take = (state_q == RD_IDLE);

  sab_rr_arb #(.N(NUM_CH)) u_arb (
    .clk(rd_clk), .rst_n(rd_rst_n), .req(req_vec), .take(arb_take),
    .gnt(arb_gnt), .gnt_idx(arb_idx), .any(arb_any)
  );

  assign out_valid = (state_q == RD_SEND);
  assign out_chan  = sel_q;
  assign out_data  = rdat[sel_q];
  assign out_last  = out_valid && (beat_q == BW'(PKT - 1));

  always_comb begin
    pop_vec = '0;
    if (out_valid && out_ready) pop_vec[sel_q] = 1'b1;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      state_q <= RD_IDLE;
      sel_q   <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        RD_IDLE: begin
          if (arb_any) begin
            sel_q   <= arb_idx;
            beat_q  <= '0;
            state_q <= RD_SEND;
          end
        end
        RD_SEND: begin
          if (out_ready) begin
            if (out_last) state_q <= RD_IDLE;
            else          beat_q  <= beat_q + 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sab_checker.sv
module sab_checker #(
  parameter int DW     = 32,
  parameter int NUM_CH = 8,
  parameter int PKT    = 242,
  localparam int CIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DW-1:0]     out_data,
  input logic [CIW-1:0]    out_chan,
  input logic              out_last,
  input logic              ovf_err,
  input logic [NUM_CH-1:0] req,
  input logic [NUM_CH-1:0] gnt
);
  int unsigned beats_q;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) beats_q <= 0;
    else if (out_valid && out_ready) beats_q <= out_last ? 0 : beats_q + 1;
  end

  AST_HOLD_ON_STALL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_last)); // R5
  AST_LAST_BEAT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_valid |-> (out_last == (beats_q == PKT - 1))); // R4
  AST_CHAN_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_valid && out_ready && !out_last |=> out_valid && $stable(out_chan)); // R4
  AST_START_REQ: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(out_valid) |-> req[out_chan]); // R3
  AST_GNT_ONEHOT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $onehot0(gnt) && ((gnt == '0) == (req == '0))); // R6
  AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ovf_err |=> ovf_err); // R7
endmodule

bind staggered_audio_buf sab_checker #(.DW(DW), .NUM_CH(NUM_CH), .PKT(PKT)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_chan(out_chan), .out_last(out_last), .ovf_err(ovf_err),
  .req(req_vec), .gnt(arb_gnt)
);

// File: tb/staggered_audio_buf_tb.sv
module staggered_audio_buf_tb;
  localparam int DW = 32, NCH = 4, DEPTH = 16, PKT = 12, ST = PKT / NCH;

  logic rd_clk = 0, wr_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic in_valid = 0;
  logic [DW-1:0] in_data = '0;
  logic out_ready = 0;
  logic ovf_err, out_valid, out_last;
  logic [DW-1:0] out_data;
  logic [1:0] out_chan;

  always #2 rd_clk = ~rd_clk;
  always #10 wr_clk = ~wr_clk;

  staggered_audio_buf #(.DW(DW), .NUM_CH(NCH), .DEPTH(DEPTH), .PKT(PKT)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_data(in_data),
    .ovf_err(ovf_err), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_chan(out_chan), .out_last(out_last)
  );

  int n_run = 0, n_fail = 0;
  int phase = 0;
  int per = 0;
  int exp_next [NCH];
  int wcnt [NCH];
  int rcnt [NCH];
  int beat = 0, cur_ch = 0, rcyc = 0;
  int first_ch [8];
  int n_first = 0;
  int post_ch [8];
  int n_post = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // output side: drive ready, then judge the beat that moves at the next edge
  always @(negedge rd_clk) begin
    rcyc++;
    if (phase == 1) out_ready = 1'b0;
    else            out_ready = (rcyc % 7 != 2) && (rcyc % 7 != 5);
    if (out_valid && out_ready && phase != 0 && phase != 1 || out_valid && out_ready && phase == 0) begin
      int c;
      c = int'(out_chan);
      if (beat == 0) begin
        cur_ch = c;
        if (phase == 0) begin
          check((wcnt[c] - rcnt[c]) >= PKT, "R3", wcnt[c] - rcnt[c], PKT);
          if (n_first < 8) first_ch[n_first++] = c;
        end else if (n_post < 8) post_ch[n_post++] = c;
        if (exp_next[c] == c * ST) check(out_data[23:0] == 24'(c * ST), "R2", int'(out_data[23:0]), c * ST);
      end else begin
        check(c == cur_ch, "R4", c, cur_ch);
      end
      check(out_data == {8'(cur_ch), 24'(exp_next[cur_ch])}, "R1",
            int'(out_data[23:0]), exp_next[cur_ch]);
      check(out_last == (beat == PKT - 1), "R4", int'(out_last), int'(beat == PKT - 1));
      exp_next[cur_ch]++;
      rcnt[cur_ch]++;
      beat = (beat == PKT - 1) ? 0 : beat + 1;
    end
  end

  task automatic send_periods(input int n, input bit gaps);
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c < NCH; c++) begin
        @(negedge wr_clk);
        in_valid = 1'b1;
        in_data  = {8'(c), 24'(per)};
        if (phase == 0 && per >= c * ST) wcnt[c]++;
        if (gaps && ((per + c) % 3 == 0)) begin
          @(negedge wr_clk);
          in_valid = 1'b0;
          in_data  = 32'hDEAD_BEEF;
        end
      end
      per++;
    end
    @(negedge wr_clk);
    in_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge rd_clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      exp_next[c] = c * ST;
      wcnt[c] = 0;
      rcnt[c] = 0;
    end
    repeat (5) @(negedge wr_clk);
    check(out_valid == 1'b0, "R8", int'(out_valid), 0);
    check(ovf_err == 1'b0, "R8", int'(ovf_err), 0);
    wr_rst_n = 1;
    rd_rst_n = 1;
    @(negedge wr_clk);
    check(out_valid == 1'b0, "R8", int'(out_valid), 0);
    check(ovf_err == 1'b0, "R8", int'(ovf_err), 0);

    // main stream with input gaps and output back-pressure
    send_periods(40, 1'b1);
    repeat (300) @(negedge rd_clk);
    for (int i = 0; i < NCH; i++) check(first_ch[i] == i, "R2", first_ch[i], i);
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
    check(ovf_err == 1'b0, "R7", int'(ovf_err), 0);
    for (int c = 0; c < NCH; c++)
      check(rcnt[c] == ((40 - c * ST) / PKT) * PKT, "R9", rcnt[c], ((40 - c * ST) / PKT) * PKT);

    // stall the reader until every channel overflows
    phase = 1;
    repeat (10) @(negedge rd_clk);
    send_periods(20, 1'b0);
    check(ovf_err == 1'b1, "R7", int'(ovf_err), 1);
    repeat (10) @(negedge wr_clk);
    check(ovf_err == 1'b1, "R7", int'(ovf_err), 1);

    // release; stored samples must still be consecutive (R7) and served in rotation
    phase = 2;
    repeat (600) @(negedge rd_clk);
    check(n_post == NCH, "R6", n_post, NCH);
    for (int i = 1; i < NCH; i++)
      check(post_ch[i] == (post_ch[0] + i) % NCH, "R6", post_ch[i], (post_ch[0] + i) % NCH);
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
    check(ovf_err == 1'b1, "R7", int'(ovf_err), 1);

    // reset clears the sticky flag
    wr_rst_n = 0;
    rd_rst_n = 0;
    repeat (3) @(negedge wr_clk);
    check(ovf_err == 1'b0, "R8", int'(ovf_err), 0);
    check(out_valid == 1'b0, "R8", int'(out_valid), 0);
    finish_run();
  end
endmodule